// File: doc/BRIEF.md
# Circular Capture Address Counter

This block produces the 15-bit address for a 32K-entry sample memory. It serves two phases. In the capture phase (write mode) it advances by one on every sample step and rolls from the top address back to zero. It keeps advancing until a downstream post-trigger stage pulls the active-low stop input low. The first trigger event of a capture copies the address present at that moment into a holding register. A host reads this register later to find where the trigger sample sits in the circular buffer.

In the readout phase (read mode) the host writes a start address through a control word and a data word. It then reads the memory in sequence. Each host read produces one step, and the address moves on to the next location after the read. The memory array and the post-trigger count are outside this block.

Every input is a plain control pin or a single-cycle strobe that the block acts on in the cycle it is sampled. No input can be held off, so there is no back-pressure. The address clock is the system clock qualified by `step_i`. The control word uses active-low bits at fixed positions.

Top module: `cap_addr_gen`

## Requirements
- R1: After reset, `addr_o` and `trig_addr_o` are both zero.
- R2: In write mode (`write_mode_i`=1), each clock with `step_i`=1 and `stop_n_i`=1 adds one to `addr_o` at that edge. The value 32767 is followed by 0.
- R3: While `stop_n_i`=0, a step never advances `addr_o`. This holds in write mode and for read-mode increments.
- R4: In read mode, a step with control bit 6 low and control bit 9 low loads `data_i[14:0]` into `addr_o`. `data_i[15]` is ignored. The load does not depend on `stop_n_i`.
- R5: When the load condition of R4 and the read-increment condition of R6 hold together, the load wins.
- R6: In read mode, a step with control bit 10 low, control bit 9 low, bit 6 high and `stop_n_i`=1 adds one to `addr_o` (post-increment after the read).
- R7: In read mode, a step with control bit 9 high leaves `addr_o` unchanged.
- R8: The snapshot register is armed after reset. When it is armed, a clock with `write_mode_i`=1 and `trig_i`=1 copies the `addr_o` value present before that edge into `trig_addr_o` and disarms the register.
- R9: While the register is disarmed, triggers leave `trig_addr_o` unchanged. Two things re-arm it: a load (R4), or a clock where `write_mode_i` differs from its value at the previous clock.
- R10: A clock with `step_i`=0 leaves `addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Address clock strobe, one per sample or host read |
| write_mode_i | input | 1 | 1 = capture (write), 0 = readout (read) |
| ctrl_i | input | 16 | Host control word; bit 6 load, bit 9 read clock, bit 10 read memory, all active low |
| data_i | input | 16 | Host load value; bits 14:0 used |
| trig_i | input | 1 | Trigger event |
| stop_n_i | input | 1 | Active-low stop from the post-trigger stage |
| addr_o | output | 15 | Memory address |
| trig_addr_o | output | 15 | Address captured at the trigger |

## Verification
On every cycle the assertions check the following:
- a write-mode step moves the address by exactly one, modulo 32768;
- the address holds while stopped in write mode or when no step arrives;
- a read-mode load lands on the supplied value;
- the trigger register changes only on a write-mode trigger.

The bench scenarios cover what needs history:
- the first-trigger-only capture;
- re-arming by a load or a mode change;
- load priority over increment;
- the wrap from 32767 to 0 reached through a real load.

// File: rtl/cap_addr_pkg.sv
package cap_addr_pkg;
  localparam int ADDR_W        = 15;
  localparam int HOST_W        = 16;
  localparam int BIT_LOAD_N    = 6;
  localparam int BIT_RDCLK_N   = 9;
  localparam int BIT_RDMEM_N   = 10;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } cap_op_e;
endpackage

// File: rtl/cap_op_decode.sv
module cap_op_decode
  import cap_addr_pkg::*;
(
  input  logic    step_i,
  input  logic    write_mode_i,
  input  logic    load_n_i,
  input  logic    rdclk_n_i,
  input  logic    rdmem_n_i,
  input  logic    stop_n_i,
  output cap_op_e op_o
);
  always_comb begin
    op_o = OP_HOLD;
    if (step_i) begin
      if (write_mode_i) begin
        if (stop_n_i) op_o = OP_INC;
      end else if (!rdclk_n_i) begin
        if (!load_n_i)                   op_o = OP_LOAD;
        else if (!rdmem_n_i && stop_n_i) op_o = OP_INC;
      end
    end
  end
endmodule

// File: rtl/cap_wrap_counter.sv
module cap_wrap_counter
  import cap_addr_pkg::*;
#(
  parameter int W = ADDR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cap_op_e      op_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD: count_o <= load_val_i;
        OP_INC:  count_o <= count_o + ONE;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/cap_trig_snap.sv
module cap_trig_snap #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         write_mode_i,
  input  logic         trig_i,
  input  logic         load_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] snap_o
);
  logic armed_q;
  logic mode_q;
  logic capture;
  logic rearm;

  assign capture = write_mode_i && trig_i && armed_q;
  assign rearm   = load_i || (write_mode_i != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_o  <= '0;
      armed_q <= 1'b1;
      mode_q  <= 1'b0;
    end else begin
      mode_q <= write_mode_i;
      if (capture) snap_o <= addr_i;
      if (rearm)        armed_q <= 1'b1;
      else if (capture) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_addr_gen.sv
module cap_addr_gen
  import cap_addr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                write_mode_i,
  input  logic [HOST_W-1:0]   ctrl_i,
  input  logic [HOST_W-1:0]   data_i,
  input  logic                trig_i,
  input  logic                stop_n_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [ADDR_W-1:0]   trig_addr_o
);
  cap_op_e op;
  logic    unused_host_bits;

  assign unused_host_bits = ^{ctrl_i, data_i[HOST_W-1:ADDR_W]};

  cap_op_decode u_dec (
    .step_i      (step_i),
    .write_mode_i(write_mode_i),
    .load_n_i    (ctrl_i[BIT_LOAD_N]),
    .rdclk_n_i   (ctrl_i[BIT_RDCLK_N]),
    .rdmem_n_i   (ctrl_i[BIT_RDMEM_N]),
    .stop_n_i    (stop_n_i),
    .op_o        (op)
  );

  cap_wrap_counter #(.W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op),
    .load_val_i(data_i[ADDR_W-1:0]),
    .count_o   (addr_o)
  );

  cap_trig_snap #(.W(ADDR_W)) u_snap (
    .clk         (clk),
    .rst_n       (rst_n),
    .write_mode_i(write_mode_i),
    .trig_i      (trig_i),
    .load_i      (op == OP_LOAD),
    .addr_i      (addr_o),
    .snap_o      (trig_addr_o)
  );
endmodule

// File: rtl/cap_addr_gen_chk.sv
module cap_addr_gen_chk
  import cap_addr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic              write_mode_i,
  input logic [HOST_W-1:0] ctrl_i,
  input logic [HOST_W-1:0] data_i,
  input logic              trig_i,
  input logic              stop_n_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] trig_addr_o
);
  // R2: write-mode step moves by one, modulo 2^15
  a_r2_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (write_mode_i && step_i && stop_n_i) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  // R3: stopped in write mode holds the address
  a_r3_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (write_mode_i && !stop_n_i) |=> $stable(addr_o));

  // R4: read-mode load takes the data bus value
  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (!write_mode_i && step_i && !ctrl_i[BIT_LOAD_N] && !ctrl_i[BIT_RDCLK_N])
      |=> addr_o == $past(data_i[ADDR_W-1:0]));

  // R10: no step, no movement
  a_r10_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(addr_o));

  // R8: snapshot only moves on a write-mode trigger
  a_r8_snap_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(write_mode_i && trig_i) |=> $stable(trig_addr_o));
endmodule

bind cap_addr_gen cap_addr_gen_chk u_chk (.*);

// File: tb/cap_addr_gen_bench.sv
module cap_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic        write_mode_i = 1'b0;
  logic [15:0] ctrl_i = 16'hFFFF;
  logic [15:0] data_i = 16'h0000;
  logic        trig_i = 1'b0;
  logic        stop_n_i = 1'b1;
  logic [14:0] addr_o;
  logic [14:0] trig_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [14:0] e_addr = '0;
  logic [14:0] e_trig = '0;
  bit          e_armed = 1'b1;
  bit          e_mode = 1'b0;

  always #5 clk = ~clk;

  cap_addr_gen u_cap_addr_gen (.*);

  localparam logic [15:0] C_IDLE = 16'hFFFF;
  localparam logic [15:0] C_LOAD = 16'hFDBF;  // bit9, bit6 low
  localparam logic [15:0] C_READ = 16'hF9FF;  // bit10, bit9 low
  localparam logic [15:0] C_BOTH = 16'hF9BF;  // bit10, bit9, bit6 low

  function automatic string addr_tag(bit st, bit wm, logic [15:0] c, bit sn);
    if (!st) return "R10";
    if (wm) return sn ? "R2" : "R3";
    if (c[9]) return "R7";
    if (!c[6]) return c[10] ? "R4" : "R5";
    if (!c[10]) return sn ? "R6" : "R3";
    return "R7";
  endfunction

  task automatic check(string tag, logic [14:0] act, logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit st, bit wm, logic [15:0] c, logic [15:0] d, bit tr, bit sn);
    bit ld, inc, cap, rearm;
    string ta, tt;
    step_i = st; write_mode_i = wm; ctrl_i = c; data_i = d; trig_i = tr; stop_n_i = sn;
    ld    = st && !wm && !c[9] && !c[6];
    inc   = st && (wm ? sn : (!c[9] && c[6] && !c[10] && sn));
    cap   = wm && tr && e_armed;
    rearm = ld || (wm != e_mode);
    ta = addr_tag(st, wm, c, sn);
    tt = cap ? "R8" : "R9";
    if (cap) e_trig = e_addr;
    e_armed = rearm ? 1'b1 : (cap ? 1'b0 : e_armed);
    e_mode = wm;
    if (ld) e_addr = d[14:0];
    else if (inc) e_addr = e_addr + 15'd1;
    @(posedge clk);
    @(negedge clk);
    check(ta, addr_o, e_addr);
    check(tt, trig_addr_o, e_trig);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", addr_o, 15'd0);
    check("R1", trig_addr_o, 15'd0);
    rst_n = 1'b1;

    // R4: load with bit 15 set, ignored
    cyc(1, 0, C_LOAD, 16'hFFFE, 0, 0);
    // R2: wrap 32766 -> 32767 -> 0, trigger on the second step (R8)
    cyc(1, 1, C_IDLE, 16'h0, 0, 1);
    cyc(1, 1, C_IDLE, 16'h0, 1, 1);
    // R9: second trigger ignored
    cyc(1, 1, C_IDLE, 16'h0, 1, 1);
    // R3: stop holds
    cyc(1, 1, C_IDLE, 16'h0, 1, 0);
    cyc(1, 1, C_IDLE, 16'h0, 0, 0);
    // R5: load beats increment
    cyc(1, 0, C_BOTH, 16'h1234, 0, 1);
    // R6: read post-increment
    cyc(1, 0, C_READ, 16'h0, 0, 1);
    cyc(1, 0, C_READ, 16'h0, 0, 1);
    // R7: read clock bit high
    cyc(1, 0, 16'hFBFF, 16'h0, 0, 1);
    // R10: no step
    cyc(0, 0, C_READ, 16'h0, 0, 1);
    // R9: mode change re-arms, new trigger captures
    cyc(1, 1, C_IDLE, 16'h0, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] c;
      c = 16'($urandom);
      case ($urandom_range(0, 3))
        0: c = C_LOAD;
        1: c = C_READ;
        default: ;
      endcase
      cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 7) < 5), c, 16'($urandom),
          ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) != 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule